// File: doc/BRIEF.md
# Shared PWM Clock-Enable Generator

This block derives the time base for a bank of PWM channels from a single master clock. A free-running binary prescaler produces eleven strobes, one for each power of two from divide-by-1 up to divide-by-1024. Two programmable dividers, A and B, each pick one of those strobes and divide it again by an 8-bit integer. A channel can choose from thirteen strobes: the eleven prescaler outputs and the two divider outputs.

Every output is a one-cycle enable pulse in the master clock domain, not a gated clock. A channel counter advances only in cycles where its chosen strobe is high. The dividers are configured by a single 32-bit mode word, written through a one-cycle write strobe. A divider whose fields change in a write restarts from zero, so its first pulse after the write never comes early.

With a 48 MHz master clock, the divide-by-64 strobe runs at 750 kHz. A period of 75 on that strobe gives 10 kHz. The same 10 kHz comes from the undivided clock with a period of 4800, at a much finer duty-cycle resolution.

Top module: `pwm_clkgen`

## Requirements
- R1: While reset is asserted, every output is low. After reset, both dividers are off (divide factor 0) until the first mode write.
- R2: Count clock edges from reset release, starting at 1. After edge e, prescaler strobe k (k = 0..10) is high exactly when e is a multiple of 2^k. Strobe 0 is therefore high on every cycle after the first edge.
- R3: Mode word fields are: divider A factor in bits 7:0, divider A strobe select in bits 11:8, divider B factor in bits 23:16, divider B strobe select in bits 27:24. The other bits are ignored.
- R4: With select s (0..10) and factor d (1..255), a divider pulses once every d pulses of prescaler strobe s, that is every d*2^s master cycles. Each pulse appears one cycle after the strobe pulse that completes the count.
- R5: A divider with factor 0 never pulses.
- R6: A divider whose select value is above 10 never pulses.
- R7: A mode write that changes a divider's factor or select clears that divider's count. The first pulse afterwards comes only after d fresh strobe pulses. For strobe 0, that is exactly d cycles after the write edge.
- R8: Dividers A and B run independently. Writing one divider's fields does not disturb the other divider's phase.
- R9: Select 6 with factor 75 gives a divider period of 4800 master cycles. Select 0 with factor 1 gives a pulse on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Write strobe for the mode word |
| mode_wdata | input | 32 | Mode word to write |
| tap_stb | output | 11 | Prescaler enable strobes; bit k is master clock divided by 2^k |
| clka_stb | output | 1 | Divider A enable strobe |
| clkb_stb | output | 1 | Divider B enable strobe |

## Verification
The assertions assume that mode_we is a synchronous, single-cycle-per-word strobe. They also assume that reset is applied before any write. The bench drives both inputs only on falling edges and drops mode_we after each word.

The select-out-of-range and zero-factor rules are checked against the stored mode word. For that reason, random mode words keep their select fields mostly in range, with occasional values above 10. Random divide factors stay small, so that many complete divider periods fit inside each window.

// File: rtl/pwm_clkgen_pkg.sv
package pwm_clkgen_pkg;
   localparam int NUM_TAPS  = 11;
   localparam int DIV_W     = 8;
   localparam int SEL_W     = 4;
   localparam int MODE_W    = 32;
   localparam int NUM_DIV   = 2;
   // field positions inside the mode word, one entry per divider
   localparam int DIV_LSB_A = 0;
   localparam int SEL_LSB_A = 8;
   localparam int DIV_LSB_B = 16;
   localparam int SEL_LSB_B = 24;

   typedef struct packed {
      logic [SEL_W-1:0] sel;
      logic [DIV_W-1:0] div;
   } div_cfg_t;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
   parameter int NUM_TAPS = 11
) (
   input  logic                clk,
   input  logic                rst_n,
   output logic [NUM_TAPS-1:0] tap_q
);
   localparam int CNT_W = NUM_TAPS - 1;

   if (NUM_TAPS < 2 || NUM_TAPS > 16) begin : g_bad_taps
      $error("pwm_prescaler: NUM_TAPS must be in 2..16");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt + CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tap_q[0] <= 1'b0;
      else        tap_q[0] <= 1'b1;
   end

   for (genvar k = 1; k < NUM_TAPS; k++) begin : g_tap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) tap_q[k] <= 1'b0;
         else        tap_q[k] <= &cnt[k-1:0];
      end
   end
endmodule

// File: rtl/pwm_mode_reg.sv
module pwm_mode_reg
   import pwm_clkgen_pkg::*;
#(
   parameter int W = MODE_W
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     we,
   input  logic [W-1:0] wdata,
   output div_cfg_t cfg   [NUM_DIV],
   output logic [NUM_DIV-1:0] restart
);
   localparam int DIV_LSB [NUM_DIV] = '{DIV_LSB_A, DIV_LSB_B};
   localparam int SEL_LSB [NUM_DIV] = '{SEL_LSB_A, SEL_LSB_B};

   if (W < SEL_LSB_B + SEL_W) begin : g_bad_w
      $error("pwm_mode_reg: mode word too narrow for the field layout");
   end

   logic unused_mode_bits;
   assign unused_mode_bits = ^{wdata[W-1:SEL_LSB_B+SEL_W],
                               wdata[DIV_LSB_B-1:SEL_LSB_A+SEL_W]};

   for (genvar d = 0; d < NUM_DIV; d++) begin : g_fld
      div_cfg_t nxt;
      assign nxt.div    = wdata[DIV_LSB[d] +: DIV_W];
      assign nxt.sel    = wdata[SEL_LSB[d] +: SEL_W];
      assign restart[d] = we && (nxt != cfg[d]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          cfg[d] <= '0;
         else if (restart[d]) cfg[d] <= nxt;
      end
   end
endmodule

// File: rtl/pwm_lin_div.sv
module pwm_lin_div
   import pwm_clkgen_pkg::*;
#(
   parameter int NT = NUM_TAPS,
   parameter int DW = DIV_W,
   parameter int SW = SEL_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NT-1:0] taps,
   input  logic [SW-1:0] sel,
   input  logic [DW-1:0] div,
   input  logic          restart,
   output logic          sel_tap,
   output logic          stb
);
   if ((1 << SW) < NT) begin : g_bad_sel
      $error("pwm_lin_div: select field cannot address every tap");
   end

   logic [DW-1:0] cnt;
   logic          sel_ok;

   always_comb begin
      sel_tap = 1'b0;
      sel_ok  = 1'b0;
      for (int i = 0; i < NT; i++) begin
         if (sel == SW'(i)) begin
            sel_tap = taps[i];
            sel_ok  = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         stb <= 1'b0;
      end else if (restart) begin
         cnt <= '0;
         stb <= 1'b0;
      end else if (sel_ok && div != '0 && sel_tap) begin
         if (cnt == div - DW'(1)) begin
            cnt <= '0;
            stb <= 1'b1;
         end else begin
            cnt <= cnt + DW'(1);
            stb <= 1'b0;
         end
      end else begin
         stb <= 1'b0;
      end
   end
endmodule

// File: rtl/pwm_clkgen.sv
module pwm_clkgen
   import pwm_clkgen_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_we,
   input  logic [MODE_W-1:0] mode_wdata,
   output logic [NUM_TAPS-1:0] tap_stb,
   output logic              clka_stb,
   output logic              clkb_stb
);
   div_cfg_t             cfg [NUM_DIV];
   logic [NUM_DIV-1:0]   restart;
   logic [NUM_DIV-1:0]   sel_tap;
   logic [NUM_DIV-1:0]   div_stb;

   pwm_prescaler #(.NUM_TAPS(NUM_TAPS)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .tap_q (tap_stb)
   );

   pwm_mode_reg #(.W(MODE_W)) u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (mode_we),
      .wdata   (mode_wdata),
      .cfg     (cfg),
      .restart (restart)
   );

   for (genvar d = 0; d < NUM_DIV; d++) begin : g_div
      pwm_lin_div #(.NT(NUM_TAPS), .DW(DIV_W), .SW(SEL_W)) u_div (
         .clk     (clk),
         .rst_n   (rst_n),
         .taps    (tap_stb),
         .sel     (cfg[d].sel),
         .div     (cfg[d].div),
         .restart (restart[d]),
         .sel_tap (sel_tap[d]),
         .stb     (div_stb[d])
      );
   end

   assign clka_stb = div_stb[0];
   assign clkb_stb = div_stb[1];
endmodule

// File: rtl/pwm_clkgen_chk.sv
module pwm_clkgen_chk
   import pwm_clkgen_pkg::*;
(
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_TAPS-1:0] tap_stb,
   input logic                clka_stb,
   input logic                clkb_stb,
   input logic [NUM_DIV-1:0]  sel_tap,
   input logic [NUM_DIV-1:0]  restart,
   input div_cfg_t            cfg [NUM_DIV]
);
   // R1: outputs quiet while reset is held
   always @(posedge clk) begin
      if (!rst_n) begin
         a_r1_quiet_in_reset: assert (tap_stb == '0 && !clka_stb && !clkb_stb)
            else $error("R1 output active during reset");
      end
   end

   // R2: a slower tap only fires together with every faster one
   for (genvar k = 1; k < NUM_TAPS; k++) begin : g_nest
      a_r2_tap_nested: assert property (@(posedge clk) disable iff (!rst_n)
         tap_stb[k] |-> tap_stb[k-1]);
   end

   // R2: divide-by-2 tap never fires twice in a row
   a_r2_half_alternates: assert property (@(posedge clk) disable iff (!rst_n)
      tap_stb[1] |=> !tap_stb[1]);

   // R4: a divider pulse follows a pulse of its selected tap
   a_r4_a_follows_tap: assert property (@(posedge clk) disable iff (!rst_n)
      clka_stb |-> $past(sel_tap[0]));
   a_r4_b_follows_tap: assert property (@(posedge clk) disable iff (!rst_n)
      clkb_stb |-> $past(sel_tap[1]));

   // R5: zero factor silences the divider
   a_r5_a_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[0].div == '0) |-> !clka_stb);
   a_r5_b_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[1].div == '0) |-> !clkb_stb);

   // R6: out-of-range select silences the divider
   a_r6_a_sel_off: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cfg[0].sel) >= NUM_TAPS) |-> !clka_stb);
   a_r6_b_sel_off: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cfg[1].sel) >= NUM_TAPS) |-> !clkb_stb);

   // R7: a restart never lets a pulse out on the next cycle
   a_r7_a_no_early: assert property (@(posedge clk) disable iff (!rst_n)
      restart[0] |=> !clka_stb);
   a_r7_b_no_early: assert property (@(posedge clk) disable iff (!rst_n)
      restart[1] |=> !clkb_stb);
endmodule

bind pwm_clkgen pwm_clkgen_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tap_stb  (tap_stb),
   .clka_stb (clka_stb),
   .clkb_stb (clkb_stb),
   .sel_tap  (sel_tap),
   .restart  (restart),
   .cfg      (cfg)
);

// File: tb/tb_pwm_clkgen.sv
module tb_pwm_clkgen;
   localparam int CLK_PERIOD = 10;
   localparam int NT = 11;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_we = 1'b0;
   logic [31:0] mode_wdata = '0;
   logic [NT-1:0] tap_stb;
   logic        clka_stb, clkb_stb;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwm_clkgen dut (
      .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
      .tap_stb(tap_stb), .clka_stb(clka_stb), .clkb_stb(clkb_stb)
   );

   function automatic int fld_div(input logic [31:0] w, input int d);
      return (d == 0) ? int'(w[7:0]) : int'(w[23:16]);
   endfunction
   function automatic int fld_sel(input logic [31:0] w, input int d);
      return (d == 0) ? int'(w[11:8]) : int'(w[27:24]);
   endfunction
   function automatic bit tap_expect(input int unsigned e, input int k);
      return (e >= 1) && ((e % (1 << k)) == 0);
   endfunction

   // reference model, stepped on each rising edge
   int unsigned m_e;
   logic [NT-1:0] m_tap;
   logic [1:0]  m_out;
   int          m_cnt [2];
   logic [31:0] m_mode;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_e = 0; m_tap = '0; m_out = '0; m_cnt[0] = 0; m_cnt[1] = 0; m_mode = '0;
      end else begin
         for (int d = 0; d < 2; d++) begin
            int s, v; bit rs, st;
            s  = fld_sel(m_mode, d);
            v  = fld_div(m_mode, d);
            rs = mode_we && (fld_sel(mode_wdata, d) != s || fld_div(mode_wdata, d) != v);
            st = (s < NT) ? m_tap[s] : 1'b0;
            if (rs) begin
               m_cnt[d] = 0; m_out[d] = 1'b0;
            end else if (s < NT && v != 0 && st) begin
               if (m_cnt[d] == v - 1) begin m_cnt[d] = 0; m_out[d] = 1'b1; end
               else begin m_cnt[d] = m_cnt[d] + 1; m_out[d] = 1'b0; end
            end else m_out[d] = 1'b0;
         end
         m_e = m_e + 1;
         for (int k = 0; k < NT; k++) m_tap[k] = tap_expect(m_e, k);
         if (mode_we) m_mode = mode_wdata;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // continuous comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(tap_stb == m_tap, "R2 taps", int'(tap_stb), int'(m_tap));
         check(clka_stb == m_out[0], "R4 divider A", int'(clka_stb), int'(m_out[0]));
         check(clkb_stb == m_out[1], "R4 divider B", int'(clkb_stb), int'(m_out[1]));
      end
   end

   task automatic write_mode(input logic [31:0] w);
      @(negedge clk);
      mode_we = 1'b1; mode_wdata = w;
      @(negedge clk);
      mode_we = 1'b0;
   endtask

   task automatic cycles_to_pulse(input int d, input int limit, output int n);
      n = 0;
      while (((d == 0) ? clka_stb : clkb_stb) == 1'b0 && n < limit) begin
         @(negedge clk); n++;
      end
   endtask

   task automatic interval(input int d, input int limit, output int n);
      int w;
      cycles_to_pulse(d, limit, w);
      @(negedge clk);
      cycles_to_pulse(d, limit, n);
      n = n + 1;
   endtask

   task automatic count_pulses(input int ncyc, output int a, output int b);
      a = 0; b = 0;
      repeat (ncyc) begin
         @(negedge clk);
         a += int'(clka_stb); b += int'(clkb_stb);
      end
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      int n, a, b;
      process::self().srandom(32'h5EED_0042);
      repeat (4) @(negedge clk);
      // R1: reset state
      check(tap_stb == '0 && !clka_stb && !clkb_stb, "R1 reset outputs",
            int'({tap_stb, clka_stb, clkb_stb}), 0);
      rst_n = 1'b1;
      count_pulses(60, a, b);
      check(a == 0 && b == 0, "R1 dividers off after reset", a + b, 0);

      // R3/R8: A = tap 2 factor 3 -> 12, B = tap 0 factor 5 -> 5; junk in ignored bits
      write_mode({4'hF, 4'd0, 8'd5, 4'hA, 4'd2, 8'd3});
      interval(0, 2000, n); check(n == 12, "R3 A field layout period", n, 12);
      interval(1, 2000, n); check(n == 5, "R3 B field layout period", n, 5);

      // R8: rewrite only B; A phase undisturbed (model checks continuously)
      write_mode({4'h0, 4'd1, 8'd7, 4'h0, 4'd2, 8'd3});
      interval(1, 2000, n); check(n == 14, "R8 B new period", n, 14);
      interval(0, 2000, n); check(n == 12, "R8 A unchanged", n, 12);

      // R9: tap 6 factor 75 -> 4800; tap 0 factor 1 -> every cycle
      write_mode({4'h0, 4'd0, 8'd1, 4'h0, 4'd6, 8'd75});
      interval(0, 6000, n); check(n == 4800, "R9 A 4800 cycles", n, 4800);
      count_pulses(20, a, b); check(b == 20, "R9 B every cycle", b, 20);

      // R5: factor zero on A, R6: select 12 on B
      write_mode({4'h0, 4'd12, 8'd4, 4'h0, 4'd3, 8'd0});
      count_pulses(300, a, b);
      check(a == 0, "R5 zero factor silent", a, 0);
      check(b == 0, "R6 select above 10 silent", b, 0);

      // R7: restart on tap 0, first pulse exactly factor cycles after write edge
      write_mode({4'h0, 4'd12, 8'd4, 4'h0, 4'd0, 8'd10});
      cycles_to_pulse(0, 100, n); check(n == 10, "R7 first pulse after restart", n, 10);
      write_mode({4'h0, 4'd12, 8'd4, 4'h0, 4'd0, 8'd9});
      cycles_to_pulse(0, 100, n); check(n == 9, "R7 restart with new factor", n, 9);

      // R2 directed: tap 10 period
      begin
         int w;
         w = 0;
         while (!tap_stb[10] && w < 3000) begin @(negedge clk); w++; end
         @(negedge clk);
         n = 1;
         while (!tap_stb[10] && n < 3000) begin @(negedge clk); n++; end
         check(n == 1024, "R2 divide-by-1024 tap period", n, 1024);
      end

      // random mode words, checked by the model
      for (int it = 0; it < 40; it++) begin
         logic [31:0] w;
         int sa, sb;
         w  = $urandom;
         sa = ($urandom % 8 == 0) ? 11 + $urandom % 5 : $urandom % 5;
         sb = ($urandom % 8 == 0) ? 11 + $urandom % 5 : $urandom % 5;
         w[11:8]  = 4'(sa);
         w[27:24] = 4'(sb);
         w[7:0]   = 8'($urandom % 12);
         w[23:16] = 8'($urandom % 12);
         write_mode(w);
         repeat (250) @(negedge clk);
      end

      finish_run();
   end
endmodule